// File: doc/BRIEF.md
# Calendar Counter with Update Cycle

This block keeps wall-clock time at one-second resolution: seconds, minutes, hours, day of week, day of month, month and a two-digit year. The time is held internally in binary and presented as encoded bytes, either packed BCD or plain binary, with the hour byte in 24-hour form or in 12-hour form with a PM marker. A companion register file supplies the control bits, the alarm bytes and the time bytes that software wrote, and asks the block to adopt those bytes with a load request.

Every one-second tick (with the oscillator selection in its running code) advances the count, handling month lengths, leap years and the century rule through a century parameter. Unless the set-hold control is active, the tick also opens an update window flagged by `uip`. The window lasts a parameterised number of 32 kHz time-base ticks; when it closes, the visible time bytes are refreshed, the alarm is compared and a one-cycle strobe tells the register file which status bits to set.

Top module: `cal_update_top`

## Requirements
- R1: After reset the time bytes read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x00, day of month 0x01, month 0x01, year 0x00, with `uip` low and `flag_set` zero.
- R2: With `bin_mode` = 1 every time byte is the plain binary value; with `bin_mode` = 0 it is packed BCD (tens in bits 7:4, units in bits 3:0). Loaded bytes are decoded the same way.
- R3: With `h24_mode` = 1 the hour byte holds 0 to 23. With `h24_mode` = 0 it holds the hour modulo 12 in bits 6:0 and bit 7 is 1 for hours 12 to 23; so noon reads 0x80 and midnight 0x00.
- R4: A second past 59 wraps to 0 and carries into minutes, minutes past 59 carry into hours, hours past 23 carry into the day; the day of week counts 0 to 6 and wraps to 0.
- R5: The day of month carries after 31, 30 (April, June, September, November) or February's length, which is 29 in a leap year and 28 otherwise; the full year is CENTURY*100 plus the two-digit year, leap when divisible by 4 and not by 100 unless by 400.
- R6: Month 12 carries into month 1 and the year byte; year 99 wraps to 0.
- R7: The time advances on `sec_tick` only when `osc_sel` equals 3'b010; any other code leaves the count and `uip` untouched.
- R8: On an advancing tick with set-hold inactive, `uip` rises on the next cycle; it falls on the edge that takes the UPD_TICKS-th `tb_tick` (8 by default), and only at that edge are the time bytes refreshed.
- R9: At the end of an update window, when `alarm_ie` is 1 and every alarm field matches the new encoded time (seconds, minutes, hours each against its own byte), `flag_set` carries bits 7 and 5 (0xA0) for one cycle.
- R10: An alarm byte whose bits 7:6 are both 1 matches any value of its field.
- R11: At the end of an update window with `upd_ie` = 1, `flag_set` carries bits 7 and 4 (0x90) for one cycle, OR-ed with the alarm bits (0xB0 when both fire); `flag_set` is zero in every other cycle.
- R12: While `set_hold` is 1, no update window opens, an open window closes with no flags, and the time bytes hold their value, but the count keeps advancing and shows up at the next refresh.
- R13: A `ld_req` pulse replaces the count with the decoded load bytes; one cycle later the time bytes show them re-encoded in the current format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle enable, once per second |
| tb_tick | input | 1 | One-cycle enable at the 32 kHz time-base rate |
| osc_sel | input | 3 | Oscillator selection; 3'b010 means running |
| set_hold | input | 1 | Freeze the visible time bytes and suppress update windows |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour hour byte, 0 = 12-hour with PM bit |
| alarm_ie | input | 1 | Alarm flag enable |
| upd_ie | input | 1 | Update-ended flag enable |
| ld_req | input | 1 | Load the count from the load bytes |
| ld_sec | input | 8 | Encoded seconds to load |
| ld_min | input | 8 | Encoded minutes to load |
| ld_hr | input | 8 | Encoded hour to load |
| ld_wday | input | 8 | Encoded day of week to load |
| ld_mday | input | 8 | Encoded day of month to load |
| ld_mon | input | 8 | Encoded month to load |
| ld_yr | input | 8 | Encoded two-digit year to load |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| t_sec | output | 8 | Encoded seconds |
| t_min | output | 8 | Encoded minutes |
| t_hr | output | 8 | Encoded hour |
| t_wday | output | 8 | Encoded day of week |
| t_mday | output | 8 | Encoded day of month |
| t_mon | output | 8 | Encoded month |
| t_yr | output | 8 | Encoded two-digit year |
| uip | output | 1 | Update window in progress |
| flag_set | output | 8 | One-cycle mask of status bits to set |

## Verification
The bench aims at the carries that are easy to get wrong: the last second of a year, February 28 in a leap year, in a common year and in year 2000, the last day of a 30-day month, and the 11:59:59 crossings in 12-hour mode where a wrong modulo would show 12 instead of 0x80 or drop the PM bit. It checks that the visible bytes stay old until the final time-base tick, which catches a design that refreshes at the start of the window or counts one tick short. Alarm tests mix exact, wildcard and mismatching fields and the enable bits, so a matcher that ignores the wildcard or compares only one field reports a wrong mask. Set-hold and a stopped oscillator are each followed by a normal second, separating a design that stops counting under set-hold from one that counts while the oscillator is off.

// File: rtl/cal_pkg.sv
package cal_pkg;

   typedef struct packed {
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hr;
      logic [2:0] wday;
      logic [4:0] mday;
      logic [3:0] mon;
      logic [6:0] yr;
   } cal_time_t;

   localparam cal_time_t CAL_RST = '{sec: 6'd0, min: 6'd0, hr: 5'd0, wday: 3'd0,
                                      mday: 5'd1, mon: 4'd1, yr: 7'd0};

   // value 0..99 to a byte in the selected format
   function automatic logic [7:0] to_enc(input logic [6:0] v, input logic bin);
      logic [6:0] tens;
      logic [6:0] ones;
      tens = v / 7'd10;
      ones = v % 7'd10;
      return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
   endfunction

   function automatic logic [6:0] from_enc(input logic [7:0] b, input logic bin);
      logic [6:0] d;
      d = ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
      return bin ? b[6:0] : d;
   endfunction

   function automatic logic [7:0] hr_enc(input logic [4:0] h, input logic bin,
                                         input logic h24);
      logic [4:0] m;
      logic       pm;
      pm = (h >= 5'd12);
      m  = pm ? h - 5'd12 : h;
      if (h24) return to_enc({2'b00, h}, bin);
      return to_enc({2'b00, m}, bin) | {pm, 7'b0};
   endfunction

   function automatic logic [4:0] hr_dec(input logic [7:0] b, input logic bin,
                                         input logic h24);
      logic [6:0] v;
      v = from_enc({1'b0, b[6:0]}, bin);
      if (!h24 && b[7]) v = v + 7'd12;
      return v[4:0];
   endfunction

   function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd2:                        return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:     return 5'd30;
         default:                     return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/cal_time_core.sv
module cal_time_core
   import cal_pkg::*;
#(
   parameter int CENTURY = 20
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  logic      ld,
   input  cal_time_t ld_val,
   output cal_time_t now
);
   localparam logic CENT_LEAP = ((CENTURY % 4) == 0);

   generate
      if (CENTURY < 0 || CENTURY > 99) begin : g_bad_century
         $error("cal_time_core: CENTURY out of range");
      end
   endgenerate

   cal_time_t  nxt;
   logic       leap;
   logic [4:0] dim;

   // full year = CENTURY*100 + yr; 100 is a multiple of 4, so yr%4 decides
   // except in year 00, where the century alone decides
   assign leap = (now.yr[1:0] == 2'b00) && ((now.yr != 7'd0) || CENT_LEAP);
   assign dim  = month_len(now.mon, leap);

   always_comb begin
      nxt = now;
      if (now.sec >= 6'd59) begin
         nxt.sec = 6'd0;
         if (now.min >= 6'd59) begin
            nxt.min = 6'd0;
            if (now.hr >= 5'd23) begin
               nxt.hr   = 5'd0;
               nxt.wday = (now.wday >= 3'd6) ? 3'd0 : now.wday + 3'd1;
               if (now.mday >= dim) begin
                  nxt.mday = 5'd1;
                  if (now.mon >= 4'd12) begin
                     nxt.mon = 4'd1;
                     nxt.yr  = (now.yr >= 7'd99) ? 7'd0 : now.yr + 7'd1;
                  end else begin
                     nxt.mon = now.mon + 4'd1;
                  end
               end else begin
                  nxt.mday = now.mday + 5'd1;
               end
            end else begin
               nxt.hr = now.hr + 5'd1;
            end
         end else begin
            nxt.min = now.min + 6'd1;
         end
      end else begin
         nxt.sec = now.sec + 6'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   now <= CAL_RST;
      else if (ld)  now <= ld_val;
      else if (adv) now <= nxt;
   end

endmodule

// File: rtl/cal_update_seq.sv
module cal_update_seq #(
   parameter int UPD_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic tb_tick,
   output logic uip,
   output logic done
);
   localparam int CW = (UPD_TICKS > 1) ? $clog2(UPD_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(UPD_TICKS - 1);

   generate
      if (UPD_TICKS < 1) begin : g_bad_ticks
         $error("cal_update_seq: UPD_TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign done = uip && tb_tick && (cnt == LAST) && !start && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uip <= 1'b0;
         cnt <= '0;
      end else if (start) begin
         uip <= 1'b1;
         cnt <= '0;
      end else if (abort || done) begin
         uip <= 1'b0;
         cnt <= '0;
      end else if (uip && tb_tick) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
   parameter int NFIELD = 3,
   parameter int BW     = 8
) (
   input  logic [NFIELD-1:0][BW-1:0] alm,
   input  logic [NFIELD-1:0][BW-1:0] cur,
   output logic                      hit
);
   generate
      if (BW < 2) begin : g_bad_bw
         $error("cal_alarm_match: BW must be at least 2");
      end
   endgenerate

   logic [NFIELD-1:0] ok;

   for (genvar i = 0; i < NFIELD; i++) begin : g_field
      assign ok[i] = (alm[i][BW-1:BW-2] == 2'b11) || (alm[i] == cur[i]);
   end

   assign hit = &ok;

endmodule

// File: rtl/cal_update_top.sv
module cal_update_top
   import cal_pkg::*;
#(
   parameter int         CENTURY   = 20,
   parameter int         UPD_TICKS = 8,
   parameter logic [2:0] OSC_RUN   = 3'b010,
   parameter logic [7:0] ALM_MASK  = 8'hA0,
   parameter logic [7:0] UPD_MASK  = 8'h90
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       tb_tick,
   input  logic [2:0] osc_sel,
   input  logic       set_hold,
   input  logic       bin_mode,
   input  logic       h24_mode,
   input  logic       alarm_ie,
   input  logic       upd_ie,
   input  logic       ld_req,
   input  logic [7:0] ld_sec,
   input  logic [7:0] ld_min,
   input  logic [7:0] ld_hr,
   input  logic [7:0] ld_wday,
   input  logic [7:0] ld_mday,
   input  logic [7:0] ld_mon,
   input  logic [7:0] ld_yr,
   input  logic [7:0] alm_sec,
   input  logic [7:0] alm_min,
   input  logic [7:0] alm_hr,
   output logic [7:0] t_sec,
   output logic [7:0] t_min,
   output logic [7:0] t_hr,
   output logic [7:0] t_wday,
   output logic [7:0] t_mday,
   output logic [7:0] t_mon,
   output logic [7:0] t_yr,
   output logic       uip,
   output logic [7:0] flag_set
);
   localparam int NALM = 3;

   cal_time_t ld_val;
   cal_time_t now;
   logic      adv;
   logic      start;
   logic      done;
   logic      hit;
   logic      ld_d;
   logic [6:0] d_sec, d_min, d_wday, d_mday, d_mon, d_yr;
   logic [7:0] e_sec, e_min, e_hr, e_wday, e_mday, e_mon, e_yr;
   logic [NALM-1:0][7:0] alm_v;
   logic [NALM-1:0][7:0] cur_v;

   assign adv   = sec_tick && (osc_sel == OSC_RUN);
   assign start = adv && !set_hold;

   // decode load bytes in the current format
   always_comb begin
      d_sec  = from_enc(ld_sec,  bin_mode);
      d_min  = from_enc(ld_min,  bin_mode);
      d_wday = from_enc(ld_wday, bin_mode);
      d_mday = from_enc(ld_mday, bin_mode);
      d_mon  = from_enc(ld_mon,  bin_mode);
      d_yr   = from_enc(ld_yr,   bin_mode);
      ld_val.sec  = d_sec[5:0];
      ld_val.min  = d_min[5:0];
      ld_val.hr   = hr_dec(ld_hr, bin_mode, h24_mode);
      ld_val.wday = d_wday[2:0];
      ld_val.mday = d_mday[4:0];
      ld_val.mon  = d_mon[3:0];
      ld_val.yr   = d_yr;
   end

   cal_time_core #(.CENTURY(CENTURY)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .ld     (ld_req),
      .ld_val (ld_val),
      .now    (now)
   );

   cal_update_seq #(.UPD_TICKS(UPD_TICKS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .abort   (set_hold),
      .tb_tick (tb_tick),
      .uip     (uip),
      .done    (done)
   );

   // encode the running count
   always_comb begin
      e_sec  = to_enc({1'b0, now.sec}, bin_mode);
      e_min  = to_enc({1'b0, now.min}, bin_mode);
      e_hr   = hr_enc(now.hr, bin_mode, h24_mode);
      e_wday = to_enc({4'b0, now.wday}, bin_mode);
      e_mday = to_enc({2'b0, now.mday}, bin_mode);
      e_mon  = to_enc({3'b0, now.mon}, bin_mode);
      e_yr   = to_enc(now.yr, bin_mode);
   end

   // field order: 0 seconds, 1 minutes, 2 hours
   assign alm_v = {alm_hr, alm_min, alm_sec};
   assign cur_v = {e_hr, e_min, e_sec};

   cal_alarm_match #(.NFIELD(NALM), .BW(8)) u_alm (
      .alm (alm_v),
      .cur (cur_v),
      .hit (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ld_d <= 1'b0;
      else        ld_d <= ld_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_sec  <= 8'h00;
         t_min  <= 8'h00;
         t_hr   <= 8'h00;
         t_wday <= 8'h00;
         t_mday <= 8'h01;
         t_mon  <= 8'h01;
         t_yr   <= 8'h00;
      end else if (!set_hold && (done || ld_d)) begin
         t_sec  <= e_sec;
         t_min  <= e_min;
         t_hr   <= e_hr;
         t_wday <= e_wday;
         t_mday <= e_mday;
         t_mon  <= e_mon;
         t_yr   <= e_yr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_set <= 8'h00;
      else if (done) flag_set <= ((alarm_ie && hit) ? ALM_MASK : 8'h00)
                                 | (upd_ie ? UPD_MASK : 8'h00);
      else           flag_set <= 8'h00;
   end

endmodule

// File: rtl/cal_update_chk.sv
module cal_update_chk #(
   parameter logic [2:0] RUN_CODE = 3'b010
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sec_tick,
   input logic [2:0] osc_sel,
   input logic       set_hold,
   input logic       uip,
   input logic [7:0] flag_set,
   input logic [7:0] t_sec
);
   // R8
   uip_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && osc_sel == RUN_CODE && !set_hold) |=> uip);

   // R7
   osc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_sel != RUN_CODE && !uip) |=> !uip);

   // R12
   set_no_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_hold |=> !uip);

   // R12
   set_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_hold |=> $stable(t_sec));

   // R11
   flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set != 8'h00) |=> (flag_set == 8'h00));

   // R9
   flag_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set != 8'h00) |-> $fell(uip));

endmodule

bind cal_update_top cal_update_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sec_tick (sec_tick),
   .osc_sel  (osc_sel),
   .set_hold (set_hold),
   .uip      (uip),
   .flag_set (flag_set),
   .t_sec    (t_sec)
);

// File: tb/tb_cal_update_top.sv
module tb_cal_update_top;
   localparam int CLK_PERIOD = 10;
   localparam int UPD = 8;
   localparam int NV = 12;

   // {bin_mode, h24_mode}
   localparam logic [1:0] VMODE [NV] = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b11,
                                         2'b00, 2'b00, 2'b10, 2'b01, 2'b01, 2'b11};
   // bytes {sec,min,hr,wday,mday,mon,yr}
   localparam logic [55:0] VLD [NV] = '{
      56'h59592306311299, 56'h59592303280224, 56'h59592303280223, 56'h56341202300421,
      56'h59592305300410, 56'h3B3B0B011F0105, 56'h59591102150630, 56'h59599102150630,
      56'h050081040A082D, 56'h59592301280200, 56'h59592304301150, 56'h3B3B17061D0204};
   localparam logic [55:0] VEXP [NV] = '{
      56'h00000000010100, 56'h00000004290224, 56'h00000004010323, 56'h57341202300421,
      56'h00000006010510, 56'h00000C011F0105, 56'h00008002150630, 56'h00000003160630,
      56'h060081040A082D, 56'h00000002290200, 56'h00000005011250, 56'h00000000010304};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_tick = 1'b0, tb_tick = 1'b0;
   logic [2:0] osc_sel = 3'b010;
   logic set_hold = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
   logic alarm_ie = 1'b0, upd_ie = 1'b0, ld_req = 1'b0;
   logic [7:0] ld_sec = 0, ld_min = 0, ld_hr = 0, ld_wday = 0, ld_mday = 0, ld_mon = 0, ld_yr = 0;
   logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
   logic [7:0] t_sec, t_min, t_hr, t_wday, t_mday, t_mon, t_yr;
   logic uip;
   logic [7:0] flag_set;

   int checks = 0;
   int failures = 0;
   logic       uip_open, uip_late, uip_end;
   logic [7:0] sec_late, flag_end;

   always #(CLK_PERIOD/2) clk = ~clk;

   cal_update_top dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tb_tick(tb_tick),
      .osc_sel(osc_sel), .set_hold(set_hold), .bin_mode(bin_mode), .h24_mode(h24_mode),
      .alarm_ie(alarm_ie), .upd_ie(upd_ie), .ld_req(ld_req),
      .ld_sec(ld_sec), .ld_min(ld_min), .ld_hr(ld_hr), .ld_wday(ld_wday),
      .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_yr(ld_yr),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
      .t_sec(t_sec), .t_min(t_min), .t_hr(t_hr), .t_wday(t_wday),
      .t_mday(t_mday), .t_mon(t_mon), .t_yr(t_yr), .uip(uip), .flag_set(flag_set));

   function automatic logic [55:0] tbytes();
      return {t_sec, t_min, t_hr, t_wday, t_mday, t_mon, t_yr};
   endfunction

   task automatic check(input logic ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [55:0] b);
      {ld_sec, ld_min, ld_hr, ld_wday, ld_mday, ld_mon, ld_yr} = b;
      @(negedge clk) ld_req = 1'b1;
      @(negedge clk) ld_req = 1'b0;
      @(negedge clk);
   endtask

   // one second with a full update window; records observations
   task automatic do_second();
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      uip_open = uip;
      for (int i = 0; i < UPD; i++) begin
         if (i == UPD - 1) begin
            uip_late = uip;
            sec_late = t_sec;
         end
         tb_tick = 1'b1;
         @(negedge clk) tb_tick = 1'b0;
      end
      uip_end  = uip;
      flag_end = flag_set;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(tbytes() == 56'h00000000010100, "R1 reset bytes", tbytes(), 56'h00000000010100);
      check(uip == 1'b0 && flag_set == 8'h00, "R1 reset flags", {uip, flag_set}, 0);

      // table: load, read back, one second, compare (R2 R3 R4 R5 R6 R13)
      for (int v = 0; v < NV; v++) begin
         {bin_mode, h24_mode} = VMODE[v];
         load(VLD[v]);
         check(tbytes() == VLD[v], "R13 load readback", tbytes(), VLD[v]);
         do_second();
         check(tbytes() == VEXP[v], "R2 R3 R4 R5 R6 vector", tbytes(), VEXP[v]);
      end

      // R8 update window timing
      bin_mode = 1'b0; h24_mode = 1'b1;
      load(56'h30201001150324);
      do_second();
      check(uip_open == 1'b1, "R8 uip raised", uip_open, 1);
      check(uip_late == 1'b1 && sec_late == 8'h30, "R8 bytes held in window",
            {uip_late, sec_late}, {1'b1, 8'h30});
      check(uip_end == 1'b0 && t_sec == 8'h31, "R8 window closed and refreshed",
            {uip_end, t_sec}, {1'b0, 8'h31});
      check(flag_end == 8'h00, "R11 no flag when disabled", flag_end, 0);

      // R11 update-ended strobe
      upd_ie = 1'b1;
      do_second();
      check(flag_end == 8'h90, "R11 update-ended mask", flag_end, 8'h90);
      check(flag_set == 8'h00, "R11 strobe one cycle", flag_set, 0);

      // R9 exact alarm match at 10:20:33
      upd_ie = 1'b0; alarm_ie = 1'b1;
      alm_sec = 8'h33; alm_min = 8'h20; alm_hr = 8'h10;
      do_second();
      check(flag_end == 8'hA0, "R9 alarm mask", flag_end, 8'hA0);

      // R10 wildcards on seconds and minutes, plus R11 combined
      upd_ie = 1'b1; alm_sec = 8'hC0; alm_min = 8'hFF;
      do_second();
      check(flag_end == 8'hB0, "R10 wildcard alarm with update", flag_end, 8'hB0);

      // R9 hour mismatch
      upd_ie = 1'b0; alm_hr = 8'h11;
      do_second();
      check(flag_end == 8'h00, "R9 hour mismatch", flag_end, 0);

      // R9 enable off, all wildcards
      alarm_ie = 1'b0; alm_sec = 8'hC0; alm_min = 8'hC0; alm_hr = 8'hC0;
      do_second();
      check(flag_end == 8'h00 && t_sec == 8'h36, "R9 alarm disabled",
            {flag_end, t_sec}, {8'h00, 8'h36});

      // R12 set-hold: no window, bytes frozen, count keeps going
      set_hold = 1'b1;
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      for (int i = 0; i < UPD; i++) begin
         tb_tick = 1'b1;
         @(negedge clk) tb_tick = 1'b0;
      end
      check(uip == 1'b0 && t_sec == 8'h36, "R12 frozen while set",
            {uip, t_sec}, {1'b0, 8'h36});
      set_hold = 1'b0;
      do_second();
      check(t_sec == 8'h38, "R12 count advanced under set", t_sec, 8'h38);

      // R7 stopped oscillator
      osc_sel = 3'b000;
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      @(negedge clk);
      check(uip == 1'b0, "R7 no window when stopped", uip, 0);
      osc_sel = 3'b010;
      do_second();
      check(t_sec == 8'h39, "R7 no advance when stopped", t_sec, 8'h39);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule